// File: doc/BRIEF.md
# Idle Timer and Low-Power Mode Controller

This block decides when the processor core may execute. A free-running timer advances on every instruction clock, and nothing can stop, load or read it. Software chooses one of five power-of-two wake-up windows. It can then park the core in an idle state, in which execution is gated off while the timer keeps counting. When the timer bit for the chosen window changes value, the block raises a pending flag, drives an interrupt request if that is enabled, and returns the core to run. An external wake-up input also ends idle.

A halt state is provided as well. Software requests it, and an option input can veto the request. Halt ends only on the external wake-up. The core then stays gated through a fixed warm-up count before it runs again. The `run_en` output is the single gate that the core uses.

Because the timer is never synchronised to software, an idle period that begins at an arbitrary moment lasts anywhere from one cycle up to the full window. Software that needs exact timing starts idle right after a pending event. Changing the window can raise the flag spuriously.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset, `wsel` is 0, `run_en` is 1, and `idle`, `halted`, `pend` and `irq` are all 0.
- R2: With window code k in 0..4, the pending flag is set once every 2^(BASE_LOG2+k) cycles. The timer keeps this rhythm in every mode.
- R3: `irq` is high exactly when `pend` is high and `irq_en` is high.
- R4: A write with `pend_we`=1 and `pend_wd`=0 clears `pend`. A write with `pend_wd`=1 leaves `pend` unchanged. Leaving idle does not clear `pend`, and a timer event in the same cycle as a clear wins.
- R5: A one-cycle `idle_req` pulse in run sets `idle` and drops `run_en` at the next clock edge.
- R6: In idle, a timer event ends idle and sets `pend` on the same edge. Idle entered one cycle after an event lasts 2^(BASE_LOG2+k)-1 cycles.
- R7: `wake_i` high in idle returns the block to run at the next edge and leaves `pend` unchanged.
- R8: If `idle_req` or `halt_req` arrives in the same cycle as `wake_i` or a timer event, the block stays in run.
- R9: A window write whose code is above 4 selects code 4. A window change sets `pend` when the newly selected timer bit differs from the previously selected one.
- R10: `halt_req` in run sets `halted` and drops `run_en` at the next edge, unless `halt_dis` is high, in which case the request is ignored. In halt, timer events and `idle_req` do not end halt.
- R11: `wake_i` in halt starts a warm-up. `run_en` stays low for exactly HALT_DLY cycles, then `halted` falls and `run_en` rises on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wsel_we | input | 1 | Write strobe for the window code |
| wsel_wd | input | SW | Window code to write |
| idle_req | input | 1 | Software request to enter idle (pulse) |
| halt_req | input | 1 | Software request to enter halt (pulse) |
| halt_dis | input | 1 | Option input that ignores halt requests |
| wake_i | input | 1 | External wake-up, synchronous to clk |
| pend_we | input | 1 | Write strobe for the pending flag |
| pend_wd | input | 1 | Data for the pending flag; only 0 acts |
| irq_en | input | 1 | Timer interrupt enable |
| wsel | output | SW | Current window code |
| pend | output | 1 | Timer pending flag |
| irq | output | 1 | Timer interrupt request |
| idle | output | 1 | Block is in idle |
| halted | output | 1 | Block is in halt or halt warm-up |
| run_en | output | 1 | Core execution enable |

## Verification
The assertions assume that `wake_i` and the request strobes are already synchronous to the instruction clock and change only between edges. They also assume that a request is a single-cycle pulse and that software never clears the flag and expects a coincident event to be lost. The bench drives every input at the falling edge. It keeps each request one cycle wide and times idle and halt entries from a just-observed pending event, so no entry is meant to collide with a timer event by accident. Collisions with `wake_i` are created only on purpose. Because the timer start value is unknown, the spurious-flag check uses two consecutive window-aligned rounds and expects the flag in exactly one of them.

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl #(
  parameter int BASE_LOG2 = 12,
  parameter int NUM_WIN   = 5,
  parameter int HALT_DLY  = 256,
  localparam int CW = BASE_LOG2 + NUM_WIN,
  localparam int SW = $clog2(NUM_WIN),
  localparam int DW = $clog2(HALT_DLY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wsel_we,
  input  logic [SW-1:0] wsel_wd,
  input  logic          idle_req,
  input  logic          halt_req,
  input  logic          halt_dis,
  input  logic          wake_i,
  input  logic          pend_we,
  input  logic          pend_wd,
  input  logic          irq_en,
  output logic [SW-1:0] wsel,
  output logic          pend,
  output logic          irq,
  output logic          idle,
  output logic          halted,
  output logic          run_en
);

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_HALT, S_WARM} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tap_q;
  logic [DW-1:0] dly;
  logic          tap_now, evt, wake_any;

  assign tap_now  = cnt[BASE_LOG2 + int'(wsel)];
  assign evt      = tap_now ^ tap_q;
  assign wake_any = evt | wake_i;

  assign irq    = pend & irq_en;
  assign run_en = (st == S_RUN);
  assign idle   = (st == S_IDLE);
  assign halted = (st == S_HALT) || (st == S_WARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      tap_q <= tap_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wsel <= '0;
    else if (wsel_we)
      wsel <= (int'(wsel_wd) > NUM_WIN - 1) ? SW'(NUM_WIN - 1) : wsel_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (evt)
      pend <= 1'b1;
    else if (pend_we && !pend_wd)
      pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      dly <= '0;
    end else begin
      unique case (st)
        S_RUN: if (!wake_any) begin
          if (halt_req && !halt_dis) st <= S_HALT;
          else if (idle_req)         st <= S_IDLE;
        end
        S_IDLE: if (wake_any) st <= S_RUN;
        S_HALT: if (wake_i) begin
          st  <= S_WARM;
          dly <= DW'(HALT_DLY - 1);
        end
        S_WARM: if (dly == '0) st <= S_RUN;
                else           dly <= dly - 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

endmodule

module idle_pwr_ctrl_chk #(
  parameter int NUM_WIN = 5,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_req,
  input logic          halt_req,
  input logic          halt_dis,
  input logic          wake_i,
  input logic          pend_we,
  input logic          pend_wd,
  input logic [SW-1:0] wsel,
  input logic          pend,
  input logic          irq,
  input logic          idle,
  input logic          halted,
  input logic          run_en
);

  p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !run_en);

  p_halt_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !run_en && !idle);

  p_irq_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !(pend_we && !pend_wd) |=> pend);

  p_idle_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle && wake_i |=> !idle && run_en);

  p_wake_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && wake_i && (idle_req || halt_req) |=> run_en);

  p_sel_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wsel) <= NUM_WIN - 1);

  p_halt_veto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && halt_req && halt_dis |=> !halted);

  p_warm_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> run_en);

endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.NUM_WIN(NUM_WIN), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .halt_req(halt_req),
  .halt_dis(halt_dis), .wake_i(wake_i), .pend_we(pend_we), .pend_wd(pend_wd),
  .wsel(wsel), .pend(pend), .irq(irq), .idle(idle), .halted(halted),
  .run_en(run_en)
);

// File: tb/sim_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_idle_pwr_ctrl;
  localparam int BASE = 3;
  localparam int DLY  = 256;

  logic clk = 0, rst_n = 0;
  logic wsel_we = 0, idle_req = 0, halt_req = 0, halt_dis = 0, wake_i = 0;
  logic pend_we = 0, pend_wd = 0, irq_en = 0;
  logic [2:0] wsel_wd = 0;
  logic [2:0] wsel;
  logic pend, irq, idle, halted, run_en;
  int total = 0, failed = 0;

  localparam int NV = 7;
  localparam int VSEL [NV] = '{0, 1, 2, 3, 4, 5, 7};
  localparam int VPER [NV] = '{8, 16, 32, 64, 128, 128, 128};
  localparam int VRD  [NV] = '{0, 1, 2, 3, 4, 4, 4};

  always #2.5 clk = ~clk;

  idle_pwr_ctrl #(.BASE_LOG2(BASE), .NUM_WIN(5), .HALT_DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .wsel_we(wsel_we), .wsel_wd(wsel_wd),
    .idle_req(idle_req), .halt_req(halt_req), .halt_dis(halt_dis),
    .wake_i(wake_i), .pend_we(pend_we), .pend_wd(pend_wd), .irq_en(irq_en),
    .wsel(wsel), .pend(pend), .irq(irq), .idle(idle), .halted(halted),
    .run_en(run_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clr_pend();
    pend_we = 1; pend_wd = 0; step(); pend_we = 0;
  endtask

  task automatic wait_pend(input string req);
    int n = 0;
    while (!pend && n < 2000) begin n++; step(); end
    if (!pend) chk({req, " timeout"}, 0, 1);
  endtask

  task automatic set_sel(input int s);
    wsel_we = 1; wsel_wd = 3'(s); step(); wsel_we = 0;
    step(); step(); clr_pend();
  endtask

  task automatic measure(output int n);
    wait_pend("R2");
    clr_pend();
    n = 1;
    while (!pend && n < 2000) begin step(); n++; end
  endtask

  task automatic spur_round(output int s);
    wait_pend("R9");
    wsel_we = 1; wsel_wd = 0; pend_we = 1; pend_wd = 0; step();
    wsel_we = 0; pend_we = 0; step();
    s = int'(pend);
    wsel_we = 1; wsel_wd = 1; pend_we = 1; pend_wd = 0; step();
    wsel_we = 0; pend_we = 0; step();
    clr_pend();
  endtask

  initial begin
    int n, s1, s2;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 wsel", int'(wsel), 0);
    chk("R1 run_en", int'(run_en), 1);
    chk("R1 idle", int'(idle), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 pend", int'(pend), 0);
    chk("R1 irq", int'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      set_sel(VSEL[i]);
      chk("R9 clamp", int'(wsel), VRD[i]);
      measure(n);
      chk("R2 period", n, VPER[i]);
    end

    set_sel(1);
    spur_round(s1);
    spur_round(s2);
    chk("R9 spurious exactly once", s1 + s2, 1);

    set_sel(0);
    wait_pend("R6");
    irq_en = 1;
    idle_req = 1; pend_we = 1; pend_wd = 0; step();
    idle_req = 0; pend_we = 0;
    chk("R5 idle", int'(idle), 1);
    chk("R5 run_en", int'(run_en), 0);
    chk("R3 irq low", int'(irq), 0);
    n = 0;
    while (idle && n < 2000) begin n++; step(); end
    chk("R6 idle length", n, 7);
    chk("R6 pend on exit", int'(pend), 1);
    chk("R6 run_en", int'(run_en), 1);
    chk("R3 irq", int'(irq), 1);
    irq_en = 0; #1;
    chk("R3 irq masked", int'(irq), 0);
    step();
    chk("R4 kept after exit", int'(pend), 1);
    pend_we = 1; pend_wd = 1; step(); pend_we = 0;
    chk("R4 write one", int'(pend), 1);
    clr_pend();
    chk("R4 write zero", int'(pend), 0);
    pend_we = 1; pend_wd = 1; step(); pend_we = 0;
    chk("R4 write one on clear", int'(pend), 0);

    wait_pend("R7");
    clr_pend();
    idle_req = 1; step(); idle_req = 0;
    chk("R7 entered", int'(idle), 1);
    wake_i = 1; step(); wake_i = 0;
    chk("R7 exit", int'(idle), 0);
    chk("R7 run_en", int'(run_en), 1);
    chk("R7 pend kept", int'(pend), 0);

    idle_req = 1; wake_i = 1; step(); idle_req = 0; wake_i = 0;
    chk("R8 idle dropped", int'(idle), 0);
    halt_req = 1; wake_i = 1; step(); halt_req = 0; wake_i = 0;
    chk("R8 halt dropped", int'(halted), 0);

    wait_pend("R10");
    clr_pend();
    halt_dis = 1; halt_req = 1; step(); halt_req = 0;
    chk("R10 vetoed", int'(halted), 0);
    chk("R10 run_en", int'(run_en), 1);
    halt_dis = 0; halt_req = 1; step(); halt_req = 0;
    chk("R10 halted", int'(halted), 1);
    chk("R10 run_en low", int'(run_en), 0);
    idle_req = 1; step(); idle_req = 0;
    repeat (20) step();
    chk("R10 stays halted", int'(halted), 1);
    chk("R10 no idle", int'(idle), 0);
    chk("R2 timer runs in halt", int'(pend), 1);

    wake_i = 1; step(); wake_i = 0;
    n = 0;
    while (!run_en && n < 2000) begin n++; step(); end
    chk("R11 warm-up", n, DLY);
    chk("R11 halted low", int'(halted), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++; failed++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule